// File: doc/BRIEF.md
# Packed Rounding High-Narrowing Subtractor

This unit is a single-stage vector datapath. It takes two 128-bit source vectors made of wide lanes. For each lane it forms either the difference or the sum of the two lanes, modulo the wide lane width. It can then add a half-LSB rounding constant. It keeps only the upper half of each wide intermediate. The narrowed lanes are packed into a 64-bit value, and that value is merged into a 128-bit destination word. The merge either fills the low half and clears the top, or fills the high half and keeps the low half of the prior destination.

The caller supplies both sources, the prior destination contents, a 2-bit element-size code, a half select, a rounding enable, an add/subtract select and an input valid. One clock later the unit returns the new destination word, an undefined-encoding flag and an output valid. Size code 3 is reserved. For that code the flag is raised and the destination is passed back unchanged. The datapath has no states. The only sequencing is the one registered stage between the input valid and the output valid.

Top module: `hnarrow_sub_unit`

## Requirements
- R1: Size code 0, 1 and 2 select narrow widths of 8, 16 and 32 bits. The source lanes are twice that width (16, 32 and 64 bits), and the unit produces 8, 4 or 2 lanes respectively.
- R2: When `sub_sel` is 1, each lane's wide intermediate is first source lane minus second source lane, modulo 2 to the wide width.
- R3: When `sub_sel` is 0, each lane's wide intermediate is first source lane plus second source lane, modulo 2 to the wide width.
- R4: When `round_en` is 1, the value 1 shifted left by (narrow width − 1) is added to the wide intermediate before narrowing. When `round_en` is 0, nothing is added, which truncates.
- R5: Narrowed lane e is bits [2w−1:w] of its wide intermediate, where w is the narrow width, and it sits at bits [e·w +: w] of the 64-bit result. No carry or borrow crosses a lane boundary.
- R6: When `upper_sel` is 0, `dst_out[63:0]` receives the result and `dst_out[127:64]` is zero.
- R7: When `upper_sel` is 1, `dst_out[127:64]` receives the result and `dst_out[63:0]` equals `dst_prev[63:0]`.
- R8: Size code 3 sets `undef_flag` to 1 and makes `dst_out` equal `dst_prev` unchanged. Valid size codes give `undef_flag` 0.
- R9: `out_valid` equals `in_valid` delayed by one clock. `dst_out` and `undef_flag` load only on cycles where `in_valid` is 1 and appear one clock later.
- R10: A synchronous active-high `rst` clears `out_valid`, `dst_out` and `undef_flag` to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| src_a | input | 128 | First source vector (wide lanes) |
| src_b | input | 128 | Second source vector (wide lanes) |
| dst_prev | input | 128 | Prior destination contents |
| elem_sz | input | 2 | Narrow element size code (0: 8, 1: 16, 2: 32, 3: reserved) |
| upper_sel | input | 1 | 0: write low half and clear high; 1: write high half and keep low |
| round_en | input | 1 | Add the half-LSB rounding constant |
| sub_sel | input | 1 | 1: subtract, 0: add |
| out_valid | output | 1 | Registered result is valid |
| dst_out | output | 128 | New destination contents |
| undef_flag | output | 1 | Reserved size code was presented |

## Verification
The assertions assume that the controls and `dst_prev` are stable and meaningful whenever `in_valid` is high. They also assume that reset is held for at least one clock edge before the first valid transfer. The stimulus drives every input on the falling edge and holds it across the capturing edge. It raises `in_valid` only after reset has been released, and it covers every combination of size code (reserved code included), half select, rounding and add/subtract. Operands include all-ones, zero, random values and lanes whose low half lies just below or exactly on the rounding boundary. This exercises carry and borrow at every lane edge.

// File: rtl/hnarrow_pkg.sv
package hnarrow_pkg;

    localparam int SRC_W     = 128;
    localparam int RES_W     = SRC_W / 2;
    localparam int NUM_SIZES = 3;
    localparam int SZ_BITS   = 2;

    typedef enum logic [SZ_BITS-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } elem_sz_e;

    function automatic int narrow_width(input int code);
        return 8 << code;
    endfunction

endpackage

// File: rtl/hnarrow_lane.sv
module hnarrow_lane #(
    parameter int NW = 8
) (
    input  logic [2*NW-1:0] wa,
    input  logic [2*NW-1:0] wb,
    input  logic            sub_sel,
    input  logic            round_en,
    output logic [NW-1:0]   hi
);
    localparam int WW = 2 * NW;
    localparam logic [WW-1:0] HALF_LSB = {{NW{1'b0}}, 1'b1, {(NW-1){1'b0}}};

    logic [WW-1:0] inter;
    logic [WW-1:0] total;
    logic [NW-1:0] lo_drop;

    always_comb begin
        inter = sub_sel ? (wa - wb) : (wa + wb);
        total = inter + (round_en ? HALF_LSB : '0);
        {hi, lo_drop} = total;
    end

endmodule

// File: rtl/hnarrow_pack.sv
module hnarrow_pack
    import hnarrow_pkg::*;
#(
    parameter int RW = RES_W
) (
    input  logic [2*RW-1:0]    src_a,
    input  logic [2*RW-1:0]    src_b,
    input  logic               sub_sel,
    input  logic               round_en,
    input  logic [SZ_BITS-1:0] elem_sz,
    output logic [RW-1:0]      res
);
    logic [NUM_SIZES-1:0][RW-1:0] per_sz;

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        localparam int NW    = 8 << k;
        localparam int LANES = RW / NW;
        for (genvar e = 0; e < LANES; e++) begin : g_lane
            hnarrow_lane #(.NW(NW)) u_lane (
                .wa       (src_a[e*2*NW +: 2*NW]),
                .wb       (src_b[e*2*NW +: 2*NW]),
                .sub_sel  (sub_sel),
                .round_en (round_en),
                .hi       (per_sz[k][e*NW +: NW])
            );
        end
    end

    always_comb begin
        unique case (elem_sz)
            SZ_BYTE: res = per_sz[0];
            SZ_HALF: res = per_sz[1];
            SZ_WORD: res = per_sz[2];
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/hnarrow_merge.sv
module hnarrow_merge #(
    parameter int RW = 64
) (
    input  logic [RW-1:0]   res,
    input  logic [2*RW-1:0] dst_prev,
    input  logic            upper_sel,
    input  logic            rsvd,
    output logic [2*RW-1:0] dst_new
);
    always_comb begin
        if (rsvd) begin
            dst_new = dst_prev;
        end else if (upper_sel) begin
            dst_new = {res, dst_prev[RW-1:0]};
        end else begin
            dst_new = {{RW{1'b0}}, res};
        end
    end

endmodule

// File: rtl/hnarrow_sub_unit.sv
module hnarrow_sub_unit
    import hnarrow_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [127:0] src_a,
    input  logic [127:0] src_b,
    input  logic [127:0] dst_prev,
    input  logic [1:0]   elem_sz,
    input  logic         upper_sel,
    input  logic         round_en,
    input  logic         sub_sel,
    output logic         out_valid,
    output logic [127:0] dst_out,
    output logic         undef_flag
);
    logic [RES_W-1:0] packed_res;
    logic [SRC_W-1:0] merged;
    logic             is_rsvd;

    assign is_rsvd = (elem_sz == SZ_RSVD);

    hnarrow_pack #(.RW(RES_W)) u_pack (
        .src_a    (src_a),
        .src_b    (src_b),
        .sub_sel  (sub_sel),
        .round_en (round_en),
        .elem_sz  (elem_sz),
        .res      (packed_res)
    );

    hnarrow_merge #(.RW(RES_W)) u_merge (
        .res       (packed_res),
        .dst_prev  (dst_prev),
        .upper_sel (upper_sel),
        .rsvd      (is_rsvd),
        .dst_new   (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            dst_out    <= '0;
            undef_flag <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dst_out    <= merged;
                undef_flag <= is_rsvd;
            end
        end
    end

    // R9
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_sz == 2'd3) |=> (undef_flag && dst_out == $past(dst_prev)));
    // R6
    low_part_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_sz != 2'd3 && !upper_sel) |=> (dst_out[127:64] == '0 && !undef_flag));
    // R7
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && elem_sz != 2'd3 && upper_sel) |=> (dst_out[63:0] == $past(dst_prev[63:0])));
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && dst_out == '0 && !undef_flag));

endmodule

// File: tb/hnarrow_sub_unit_tb.sv
module hnarrow_sub_unit_tb;

    typedef struct {
        logic [127:0] dst;
        logic         undef;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] dst_prev = '0;
    logic [1:0]   elem_sz = '0;
    logic         upper_sel = 1'b0;
    logic         round_en = 1'b0;
    logic         sub_sel = 1'b0;
    logic         out_valid;
    logic [127:0] dst_out;
    logic         undef_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    hnarrow_sub_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .dst_prev(dst_prev),
        .elem_sz(elem_sz), .upper_sel(upper_sel), .round_en(round_en),
        .sub_sel(sub_sel), .out_valid(out_valid), .dst_out(dst_out),
        .undef_flag(undef_flag)
    );

    // Behavioural reference taken from R1..R8
    function automatic exp_t model(input logic [127:0] a, input logic [127:0] b,
                                   input logic [127:0] prev, input logic [1:0] sz,
                                   input logic up, input logic rnd, input logic sub);
        exp_t r;
        int w;
        logic [63:0] m2, m1, ea, eb, s, res;
        r.tag = "";
        if (sz == 2'd3) begin
            r.dst = prev;
            r.undef = 1'b1;
            return r;
        end
        w = 8 << sz;
        m2 = (w == 32) ? '1 : ((64'd1 << (2*w)) - 64'd1);
        m1 = (64'd1 << w) - 64'd1;
        res = '0;
        for (int e = 0; e < 64 / w; e++) begin
            ea = 64'((a >> (e*2*w))) & m2;
            eb = 64'((b >> (e*2*w))) & m2;
            s = sub ? (ea - eb) : (ea + eb);
            if (rnd) s = s + (64'd1 << (w-1));
            s = s & m2;
            res = res | (((s >> w) & m1) << (e*w));
        end
        r.dst = up ? {res, prev[63:0]} : {64'd0, res};
        r.undef = 1'b0;
        return r;
    endfunction

    // Lanes holding (e+1) in the high half and a low half just below or at the boundary
    function automatic logic [127:0] bnd_pat(input logic [1:0] sz, input bit at);
        logic [127:0] v = '0;
        int w;
        logic [127:0] lane;
        w = (sz == 2'd3) ? 8 : (8 << sz);
        for (int e = 0; e < 64 / w; e++) begin
            lane = (128'(e+1) << w) |
                   (at ? (128'd1 << (w-1)) : ((128'd1 << (w-1)) - 128'd1));
            v = v | (lane << (e*2*w));
        end
        return v;
    endfunction

    task automatic drive(input logic [127:0] a, input logic [127:0] b,
                         input logic [1:0] sz, input logic up,
                         input logic rnd, input logic sub);
        exp_t x;
        logic [127:0] prev;
        prev = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        in_valid = 1'b1;
        src_a = a; src_b = b; dst_prev = prev;
        elem_sz = sz; upper_sel = up; round_en = rnd; sub_sel = sub;
        x = model(a, b, prev, sz, up, rnd, sub);
        x.tag = (sz == 2'd3) ? "R8" :
                {"R1 R5 ", sub ? "R2 " : "R3 ", "R4 ", up ? "R7" : "R6"};
        sb.push_back(x);
    endtask

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard when the design presents a result
    initial begin
        exp_t x;
        forever begin
            @(negedge clk);
            #1;
            if (!rst && out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9 unexpected out_valid", 128'(out_valid), 128'd0);
                end else begin
                    x = sb.pop_front();
                    check(dst_out == x.dst, x.tag, dst_out, x.dst);
                    check(undef_flag == x.undef, {x.tag, " R8 flag"},
                          128'(undef_flag), 128'(x.undef));
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [127:0] pa, pb;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(out_valid == 1'b0 && dst_out == '0 && undef_flag == 1'b0,
              "R10 reset", dst_out, 128'd0);
        rst = 1'b0;
        @(negedge clk);
        // R9 idle: no valid in, no valid out
        check(out_valid == 1'b0, "R9 idle", 128'(out_valid), 128'd0);
        for (int sz = 0; sz < 4; sz++) begin
            for (int mode = 0; mode < 8; mode++) begin
                for (int p = 0; p < 6; p++) begin
                    case (p)
                        0: begin pa = '1; pb = '1; end
                        1: begin pa = '0; pb = '0; end
                        2: begin pa = '0; pb = '1; end
                        3: begin pa = bnd_pat(2'(sz), 1'b0); pb = '0; end
                        4: begin pa = bnd_pat(2'(sz), 1'b1); pb = '0; end
                        default: begin
                            pa = {$urandom, $urandom, $urandom, $urandom};
                            pb = {$urandom, $urandom, $urandom, $urandom};
                        end
                    endcase
                    drive(pa, pb, 2'(sz), mode[0], mode[1], mode[2]);
                end
            end
            // gap cycle between groups to exercise R9 hold behaviour
            @(negedge clk);
            in_valid = 1'b0;
            src_a = '1;
            elem_sz = 2'd3;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R9 every issued item was returned
        check(sb.size() == 0, "R9 drain", 128'(sb.size()), 128'd0);
        // R9 outputs held while idle after inputs changed
        begin
            logic [127:0] held;
            held = dst_out;
            src_b = '1;
            elem_sz = 2'd0;
            @(negedge clk);
            check(dst_out == held && out_valid == 1'b0, "R9 hold", dst_out, held);
        end
        rst = 1'b1;
        @(negedge clk);
        // R10 reset after activity
        check(out_valid == 1'b0 && dst_out == '0 && undef_flag == 1'b0,
              "R10 late reset", dst_out, 128'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule